// File: doc/BRIEF.md
# I2C Master Bus Timing Generator

This block turns a system clock and an 8-bit divider code into the SCL waveform and the SDA change points that an I2C master needs. The code is decoded into a multiplier and a set of tap parameters. From these come four timings: the SCL half period, the SDA hold after SCL falls, the START hold and the STOP setup. A controller above the block asks for a START, then one data bit at a time, then a STOP. Each finished request is reported with a one-cycle `done` pulse.

Both bus lines are open-drain. The block drives each line through a pull-low enable and reads the pad level back through a two-flop synchroniser. The high half of every SCL period is counted from the level sensed on the pad, not from the level the block drives. If another master or a slave holds SCL low, the high half is stretched, and the clocks of several masters stay in step. The counter runs freely for as many cycles as the synchroniser delays the pad, so a bus that nobody holds keeps the nominal period.

Top module: `i2c_mstr_timing`

## Requirements
- R1: The divider code splits into three fields. Bits [7:6] select MUL: 00 gives 1, 01 gives 2, 10 gives 4, and 11 also gives 4. Bits [2:0] = 0..7 select the SCL tap (5,6,7,8,9,10,12,15) and the SDA tap (1,1,2,2,3,3,4,4). Bits [5:3] select the group constants (tap step, scl-to-tap, scl-to-start, scl-to-stop): groups 0 and 1 give (1,4,2,7), groups 2 and 3 give (2,6,2,9), groups 4 and 5 give (4,14,6,17), and groups 6 and 7 give (8,30,14,33).
- R2: The SCL half period H = MUL*(scl2tap + (SCL tap-1)*step + 2) clocks, so the full period is 2H. With MUL=1, codes 0x00..0x05 give full periods of 20, 22, 24, 26, 28 and 30 clocks.
- R3: The SDA hold D = MUL*(scl2tap + (SDA tap-1)*step + 3) clocks. It is always shorter than H. SDA changes D clocks after the edge that accepts a bit or STOP request, while SCL is driven low.
- R4: The START hold = MUL*(scl2start + (SCL tap-1)*step) clocks. It is measured from SDA being driven low to SCL being driven low.
- R5: The STOP setup = MUL*(scl2stop + (SCL tap-1)*step) clocks. It is measured from SCL being released to SDA being released.
- R6: After reset, and whenever the block is idle, both pull-low enables are off and `done` is low.
- R7: A START request is taken only when the block is idle. SDA is driven low on the accepting edge, and SCL is driven low START-hold clocks later. The block then holds SCL low until the next request.
- R8: A bit request keeps SCL low for H clocks after the accepting edge. SDA takes the latched bit value at D clocks (a 1 releases the line, a 0 pulls it low). SCL is then released, and it is driven low again on the H-th clock edge after the sensed rise. On an uncontested bus that is 2H clocks after acceptance.
- R9: After SCL is released, the high-half counter may advance by two counts, which covers the synchroniser delay. After that it waits until the synchronised SCL input reads high. If another agent holds SCL low, the high half starts when the line actually rises.
- R10: A STOP request pulls SDA low at D clocks and releases SCL at H clocks. It releases SDA STOP-setup clocks later, counted with the same sensed-level rule as R9, and the block returns to idle.
- R11: Bit and STOP requests are ignored while idle, and a START request is ignored while the bus is held. When STOP and bit are requested together, the STOP is performed.
- R12: `done` is high for exactly one cycle. It rises on the edge that completes a START (with SCL going low), a bit (with SCL going low) or a STOP (with SDA released).
- R13: SDA does not change during the high half of a data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_code | input | 8 | Divider code; hold stable while not idle |
| start_req | input | 1 | Request a START condition |
| bit_req | input | 1 | Request one clocked data bit |
| bit_val | input | 1 | Data bit value, sampled with bit_req |
| stop_req | input | 1 | Request a STOP condition |
| scl_in | input | 1 | Sensed SCL pad level |
| sda_in | input | 1 | Sensed SDA pad level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every output change is due a fixed number of clock edges after the edge that accepts a request. The SDA change is due at D, the SCL release at H, SCL low again at 2H plus any stretch, and STOP completion at H plus the STOP setup. The START drop of SCL is due at the START hold. For each cycle of an operation, the bench builds the full expected trace of both enables and `done` from those offsets. It compares that trace on the falling clock edge, half a cycle after the register that drives the output has settled. Stretch tests release the external pull-down on a known falling edge, so the due cycle of the SCL fall moves by exactly the number of cycles held.

// File: rtl/i2c_tim_pkg.sv
package i2c_tim_pkg;

    localparam int TW = 10;
    typedef logic [TW-1:0] tcnt_t;

    typedef struct packed {
        tcnt_t half;
        tcnt_t sda_hold;
        tcnt_t start_hold;
        tcnt_t stop_setup;
    } bus_tim_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_HELD,
        ST_LOW,
        ST_HIGH,
        ST_STOP_LOW,
        ST_STOP_SETUP
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        tcnt_t   cnt;
        logic    bval;
        logic    scl_oe;
        logic    sda_oe;
        logic    done;
    } seq_t;

    function automatic bus_tim_t decode_tim(input logic [7:0] code);
        int mul, sclt, sdat, step, s2t, s2a, s2p;
        bus_tim_t r;
        case (code[7:6])
            2'b00:   mul = 1;
            2'b01:   mul = 2;
            default: mul = 4;
        endcase
        case (code[2:0])
            3'd0: begin sclt = 5;  sdat = 1; end
            3'd1: begin sclt = 6;  sdat = 1; end
            3'd2: begin sclt = 7;  sdat = 2; end
            3'd3: begin sclt = 8;  sdat = 2; end
            3'd4: begin sclt = 9;  sdat = 3; end
            3'd5: begin sclt = 10; sdat = 3; end
            3'd6: begin sclt = 12; sdat = 4; end
            default: begin sclt = 15; sdat = 4; end
        endcase
        case (code[5:4])
            2'd0: begin step = 1; s2t = 4;  s2a = 2;  s2p = 7;  end
            2'd1: begin step = 2; s2t = 6;  s2a = 2;  s2p = 9;  end
            2'd2: begin step = 4; s2t = 14; s2a = 6;  s2p = 17; end
            default: begin step = 8; s2t = 30; s2a = 14; s2p = 33; end
        endcase
        r.half       = tcnt_t'(mul * (s2t + (sclt - 1) * step + 2));
        r.sda_hold   = tcnt_t'(mul * (s2t + (sdat - 1) * step + 3));
        r.start_hold = tcnt_t'(mul * (s2a + (sclt - 1) * step));
        r.stop_setup = tcnt_t'(mul * (s2p + (sclt - 1) * step));
        return r;
    endfunction

endpackage

// File: rtl/i2c_tim_decode.sv
module i2c_tim_decode
    import i2c_tim_pkg::*;
(
    input  logic [7:0] div_code,
    output bus_tim_t   tim
);

    always_comb begin
        tim = decode_tim(div_code);
    end

    // The SDA change point must fall inside the low half of SCL.
    always_comb begin
        AST_HOLD_INSIDE_LOW: assert (tim.sda_hold < tim.half); // R3
    end

endmodule

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = line_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], line_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign line_o = sh_q[STAGES-1];

endmodule

// File: rtl/i2c_mstr_timing.sv
module i2c_mstr_timing
    import i2c_tim_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] div_code,
    input  logic       start_req,
    input  logic       bit_req,
    input  logic       bit_val,
    input  logic       stop_req,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       done
);

    localparam tcnt_t LAT     = tcnt_t'(SYNC_STAGES);
    localparam tcnt_t ONE     = tcnt_t'(1);
    localparam seq_t  SEQ_RST = '{st: ST_IDLE, cnt: '0, bval: 1'b0,
                                  scl_oe: 1'b0, sda_oe: 1'b0, done: 1'b0};

    bus_tim_t tim;
    logic     scl_s, sda_s;
    logic     adv_hi, adv_st;
    seq_t     seq_d, seq_q;

    i2c_tim_decode u_dec (
        .div_code (div_code),
        .tim      (tim)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (scl_in),
        .line_o (scl_s)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (sda_in),
        .line_o (sda_s)
    );

    // Free-run over the synchroniser latency, then follow the sensed pad.
    assign adv_hi = (seq_q.cnt < LAT) || scl_s;
    assign adv_st = (seq_q.cnt < LAT) || !sda_s;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start_req) begin
                    seq_d.st     = ST_START;
                    seq_d.cnt    = '0;
                    seq_d.sda_oe = 1'b1;
                end
            end
            ST_START: begin
                if (adv_st) begin
                    if (seq_q.cnt == tim.start_hold - ONE) begin
                        seq_d.st     = ST_HELD;
                        seq_d.cnt    = '0;
                        seq_d.scl_oe = 1'b1;
                        seq_d.done   = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + ONE;
                    end
                end
            end
            ST_HELD: begin
                if (stop_req) begin
                    seq_d.st  = ST_STOP_LOW;
                    seq_d.cnt = '0;
                end else if (bit_req) begin
                    seq_d.st   = ST_LOW;
                    seq_d.cnt  = '0;
                    seq_d.bval = bit_val;
                end
            end
            ST_LOW, ST_STOP_LOW: begin
                seq_d.cnt = seq_q.cnt + ONE;
                if (seq_q.cnt == tim.sda_hold - ONE) begin
                    seq_d.sda_oe = (seq_q.st == ST_LOW) ? !seq_q.bval : 1'b1;
                end
                if (seq_q.cnt == tim.half - ONE) begin
                    seq_d.st     = (seq_q.st == ST_LOW) ? ST_HIGH : ST_STOP_SETUP;
                    seq_d.cnt    = '0;
                    seq_d.scl_oe = 1'b0;
                end
            end
            ST_HIGH: begin
                if (adv_hi) begin
                    if (seq_q.cnt == tim.half - ONE) begin
                        seq_d.st     = ST_HELD;
                        seq_d.cnt    = '0;
                        seq_d.scl_oe = 1'b1;
                        seq_d.done   = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + ONE;
                    end
                end
            end
            ST_STOP_SETUP: begin
                if (adv_hi) begin
                    if (seq_q.cnt == tim.stop_setup - ONE) begin
                        seq_d.st     = ST_IDLE;
                        seq_d.cnt    = '0;
                        seq_d.sda_oe = 1'b0;
                        seq_d.done   = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + ONE;
                    end
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign scl_oe = seq_q.scl_oe;
    assign sda_oe = seq_q.sda_oe;
    assign done   = seq_q.done;

    AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE) |-> (!scl_oe && !sda_oe)); // R6
    AST_HELD_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_HELD) |-> scl_oe); // R7
    AST_CNT_IN_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_LOW || seq_q.st == ST_STOP_LOW) |-> (seq_q.cnt < tim.half)); // R2
    AST_FALL_AFTER_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_oe) && $past(seq_q.st) == ST_HIGH) |-> $past(scl_s)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_SDA_FROZEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_HIGH) |=> $stable(sda_oe)); // R13

endmodule

// File: tb/i2c_mstr_timing_test.sv
module i2c_mstr_timing_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_code = 8'h00;
    logic       start_req = 1'b0;
    logic       bit_req = 1'b0;
    logic       bit_val = 1'b0;
    logic       stop_req = 1'b0;
    logic       ext_low = 1'b0;
    logic       scl_in, sda_in;
    logic       scl_oe, sda_oe, done;

    int  vecs = 0;
    int  errs = 0;
    logic p_sda = 1'b0;

    always #10 clk = ~clk;

    // Open-drain pads: released lines float high.
    assign scl_in = ~(scl_oe | ext_low);
    assign sda_in = ~sda_oe;

    i2c_mstr_timing uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_code  (div_code),
        .start_req (start_req),
        .bit_req   (bit_req),
        .bit_val   (bit_val),
        .stop_req  (stop_req),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .done      (done)
    );

    // Timing model from R1..R5.
    function automatic int f_mul(input logic [7:0] c);
        return (c[7:6] == 2'b00) ? 1 : (c[7:6] == 2'b01) ? 2 : 4;
    endfunction
    function automatic int f_sclt(input logic [7:0] c);
        int t[8] = '{5, 6, 7, 8, 9, 10, 12, 15};
        return t[c[2:0]];
    endfunction
    function automatic int f_sdat(input logic [7:0] c);
        return 1 + c[2:1];
    endfunction
    function automatic int f_grp(input logic [7:0] c, input int which);
        int g = c[5:4];
        int stp[4] = '{1, 2, 4, 8};
        int s2t[4] = '{4, 6, 14, 30};
        int s2a[4] = '{2, 2, 6, 14};
        int s2p[4] = '{7, 9, 17, 33};
        case (which)
            0: return stp[g];
            1: return s2t[g];
            2: return s2a[g];
            default: return s2p[g];
        endcase
    endfunction
    function automatic int f_half(input logic [7:0] c);
        return f_mul(c) * (f_grp(c, 1) + (f_sclt(c) - 1) * f_grp(c, 0) + 2);
    endfunction
    function automatic int f_hold(input logic [7:0] c);
        return f_mul(c) * (f_grp(c, 1) + (f_sdat(c) - 1) * f_grp(c, 0) + 3);
    endfunction
    function automatic int f_start(input logic [7:0] c);
        return f_mul(c) * (f_grp(c, 2) + (f_sclt(c) - 1) * f_grp(c, 0));
    endfunction
    function automatic int f_stop(input logic [7:0] c);
        return f_mul(c) * (f_grp(c, 3) + (f_sclt(c) - 1) * f_grp(c, 0));
    endfunction

    task automatic chk(input string tag, input string what, input int n,
                       input logic act, input logic exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s code=%02h n=%0d actual=%b expected=%b",
                     tag, what, div_code, n, act, exp);
        end
    endtask

    task automatic chk_all(input string t_scl, input string t_sda, input string t_done,
                           input int n, input logic e_scl, input logic e_sda, input logic e_done);
        chk(t_scl, "scl_oe", n, scl_oe, e_scl);
        chk(t_sda, "sda_oe", n, sda_oe, e_sda);
        chk(t_done, "done", n, done, e_done);
    endtask

    task automatic gap(input int cycles, input logic held);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (held) chk_all("R7", "R11", "R12", i, 1'b1, p_sda, 1'b0);
            else      chk_all("R6", "R6", "R6", i, 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic run_start(input string scl_tag);
        int sh = f_start(div_code);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        for (int n = 0; n <= sh + 2; n++) begin
            if (n > 0) @(negedge clk);
            chk_all(scl_tag, "R7", "R12", n, n >= sh, 1'b1, n == sh);
        end
        p_sda = 1'b1;
    endtask

    task automatic run_bit(input logic v, input int s, input string scl_tag);
        int h = f_half(div_code);
        int d = f_hold(div_code);
        if (s > 0) ext_low = 1'b1;
        bit_req = 1'b1;
        bit_val = v;
        @(negedge clk);
        bit_req = 1'b0;
        for (int n = 0; n <= 2 * h + s + 2; n++) begin
            if (n > 0) @(negedge clk);
            chk_all((s > 0) ? "R9" : scl_tag, (n < h) ? "R3" : "R13", "R12", n,
                    (n < h) || (n >= 2 * h + s),
                    (n < d) ? p_sda : ~v,
                    n == 2 * h + s);
            if (s > 0 && n == h + s) ext_low = 1'b0;
        end
        p_sda = ~v;
    endtask

    task automatic run_stop(input logic with_bit);
        int h  = f_half(div_code);
        int d  = f_hold(div_code);
        int ss = f_stop(div_code);
        stop_req = 1'b1;
        if (with_bit) begin
            bit_req = 1'b1;
            bit_val = 1'b1;
        end
        @(negedge clk);
        stop_req = 1'b0;
        bit_req  = 1'b0;
        for (int n = 0; n <= h + ss + 2; n++) begin
            if (n > 0) @(negedge clk);
            chk_all(with_bit ? "R11" : "R10", (n < h) ? "R3" : "R5", "R12", n,
                    n < h,
                    (n < d) ? p_sda : (n < h + ss),
                    n == h + ss);
        end
        p_sda = 1'b0;
    endtask

    task automatic frame(input logic [7:0] code, input int nbits, input string scl_tag,
                         input logic rnd);
        div_code = code;
        gap(2, 1'b0);
        run_start(scl_tag);
        for (int b = 0; b < nbits; b++) begin
            logic v = rnd ? logic'($urandom % 2) : logic'(b % 2 == 0);
            int   s = (rnd && ($urandom % 3 == 0)) ? int'($urandom % 20) : 0;
            gap(rnd ? int'($urandom % 4) : 0, 1'b1);
            run_bit(v, s, scl_tag);
        end
        gap(rnd ? int'($urandom % 4) : 1, 1'b1);
        run_stop(rnd && ($urandom % 4 == 0));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R6: reset state
        gap(3, 1'b0);

        // R11: bit and stop requests in idle do nothing
        bit_req  = 1'b1;
        stop_req = 1'b1;
        @(negedge clk);
        bit_req  = 1'b0;
        stop_req = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk_all("R11", "R11", "R11", i, 1'b0, 1'b0, 1'b0);
        end

        // R1 / R2: table sweep of the tap codes and multipliers
        for (int c = 0; c < 8; c++) frame(8'(c), 2, "R2", 1'b0);
        frame(8'h40, 2, "R1", 1'b0);
        frame(8'h80, 2, "R1", 1'b0);
        frame(8'hC0, 2, "R1", 1'b0);
        frame(8'h1B, 2, "R1", 1'b0);
        frame(8'h2E, 1, "R1", 1'b0);

        // R9: stretched high halves; R11: start ignored while held
        div_code = 8'h03;
        gap(2, 1'b0);
        run_start("R4");
        run_bit(1'b0, 1, "R8");
        run_bit(1'b1, 7, "R8");
        run_bit(1'b0, 40, "R8");
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk_all("R11", "R11", "R11", i, 1'b1, p_sda, 1'b0);
        end
        run_bit(1'b1, 0, "R8");
        // R11: stop wins over a simultaneous bit request
        run_stop(1'b1);

        // Random frames
        for (int f = 0; f < 10; f++) begin
            frame(8'($urandom), 1 + int'($urandom % 4), "R8", 1'b1);
        end
        gap(3, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule